// File: doc/BRIEF.md
# Thermal ADC Auto-Monitor Controller

This block runs a temperature-sensing ADC without software help once it is set up. It steps through the sensor channels in turn. For each conversion it pulses a start strobe with a channel number, waits for the converter's done pulse and keeps the 12-bit result. The code falls as the die heats up, from roughly 3800 when cold to roughly 3420 when hot. Each stored code is compared against a shutdown threshold for its channel. Channel slot 0 is reserved and is never converted. Slots 1 and 2 are the monitored sensors.

A channel whose code stays at or below its threshold for a programmed number of consecutive samples raises an interrupt-pending bit. A second, separate count of such samples latches a thermal shutdown. Each channel routes its shutdown to a board pin with selectable polarity, or to a chip-reset request, or to both. While any enabled channel reads hot, the wait between conversions drops from the normal period to a shorter hot period. Waits are counted in cycles where the timebase `tick` input is high.

Software reaches the block over a simple bus. A write happens in the cycle where `bus_sel` and `bus_wr` are both high. Reads return a combinational value for `bus_addr`. The map is: control 0x04, enable 0x08, interrupt pending 0x0C, channel data 0x20+4·ch, channel threshold 0x40+4·ch, interrupt debounce 0x60, shutdown debounce 0x64, normal period 0x68, hot period 0x6C.

Top module: `tadc_monitor`

## Requirements
- R1: After reset the data registers, the pending register, `irq` and `shut_rst` read 0. `shut_pin` sits at its inactive level, which is high because the polarity bit resets to 0. The period registers read 250 (normal) and 50 (hot), and both debounce registers read 4.
- R2: Control (0x04) holds auto-enable in bit 0, source enable for channel ch in bit 4+ch, and shutdown polarity in bit 8, where 1 means active high. Enable (0x08) holds the interrupt enable in bit ch, the pin route in bit 4+ch and the reset route in bit 8+ch. All of these fields read back as written.
- R3: With auto-enable set, conversions go round-robin over the channels 1..2 whose source bit is set. Channel 0 is never converted. `adc_start` is a one-cycle pulse, and `adc_chan` gives the channel.
- R4: The `adc_code` value present with `adc_done` is stored in that channel's data register. Channels not yet converted read 0.
- R5: After each result, the block waits for the normal-period number of `tick` cycles before the next start. With `tick` high every cycle and a 3-cycle converter, starts are 25 cycles apart for a period of 20. With `tick` held low, no new conversion starts.
- R6: While any source-enabled channel's stored code is at or below its threshold, the hot period is used instead. With the same converter and a hot period of 5, starts are 10 cycles apart.
- R7: A sample is over threshold when code <= threshold. Equality counts.
- R8: A channel's pending bit sets only on the sample that completes the interrupt-debounce count of consecutive over-threshold samples. A sample that is not over threshold restarts the count.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it set. `irq` is the OR of the pending bits whose interrupt enable is set.
- R10: After the shutdown-debounce count of consecutive over-threshold samples, the channel's shutdown latches. It stays latched until reset, even when later samples are cool.
- R11: A latched shutdown on a pin-routed channel drives `shut_pin` to its active level, set by the polarity bit. A latched shutdown on a reset-routed channel raises `shut_rst`.
- R12: Clearing auto-enable lets a conversion already in flight complete and be stored. No further start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick that advances the period counter |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| adc_start | output | 1 | Conversion start pulse |
| adc_chan | output | 2 | Channel to convert |
| adc_done | input | 1 | Conversion complete pulse |
| adc_code | input | 12 | Conversion result, valid with adc_done |
| irq | output | 1 | Level interrupt |
| shut_pin | output | 1 | Thermal shutdown pin, polarity programmable |
| shut_rst | output | 1 | Chip-reset request |

## Verification
The bench aims at the debounce edges. A code exactly equal to the threshold must count as hot; a strict comparison would never raise the interrupt in that test. An over/cool/over run that adds up to the count but is not consecutive must leave `irq` low; a counter that never restarts would fire early. Measured start intervals with normal and hot periods catch an off-by-one in the wait, and a stalled `tick` catches a counter that runs on the clock. Cooling after a shutdown and dropping auto-enable mid-conversion check that the latch holds and that the conversion in flight is still stored.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  localparam int CODE_W = 12;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_START, SQ_BUSY} seq_state_e;
endpackage

// File: rtl/tadc_regs.sv
module tadc_regs
  import tadc_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int PER_W    = 16,
  parameter int DB_W     = 8,
  parameter int DEF_NORM = 250,
  parameter int DEF_HOT  = 50,
  parameter int DEF_DB   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NCH-1:0][CODE_W-1:0]    chan_data,
  input  logic [NCH-1:0]                int_evt,
  output logic                          auto_en,
  output logic [NCH-1:0]                src_en,
  output logic                          shut_pol,
  output logic [NCH-1:0]                int_en,
  output logic [NCH-1:0]                pin_en,
  output logic [NCH-1:0]                rst_en,
  output logic [NCH-1:0][CODE_W-1:0]    thr,
  output logic [DB_W-1:0]               int_db,
  output logic [DB_W-1:0]               shut_db,
  output logic [PER_W-1:0]              norm_per,
  output logic [PER_W-1:0]              hot_per,
  output logic [NCH-1:0]                pend
);
  localparam logic [7:0] A_CTRL  = 8'h04;
  localparam logic [7:0] A_ENA   = 8'h08;
  localparam logic [7:0] A_PEND  = 8'h0C;
  localparam logic [7:0] A_DATA0 = 8'h20;
  localparam logic [7:0] A_THR0  = 8'h40;
  localparam logic [7:0] A_IDB   = 8'h60;
  localparam logic [7:0] A_SDB   = 8'h64;
  localparam logic [7:0] A_NPER  = 8'h68;
  localparam logic [7:0] A_HPER  = 8'h6C;

  logic wr;
  logic unused_wdata;
  logic                       auto_q, auto_d, pol_q, pol_d;
  logic [NCH-1:0]             src_q, src_d, ien_q, ien_d, pen_q, pen_d, ren_q, ren_d;
  logic [NCH-1:0]             pend_q, pend_d, clr;
  logic [NCH-1:0][CODE_W-1:0] thr_q, thr_d;
  logic [DB_W-1:0]            idb_q, idb_d, sdb_q, sdb_d;
  logic [PER_W-1:0]           nper_q, nper_d, hper_q, hper_d;

  assign wr           = bus_sel && bus_wr;
  assign unused_wdata = &{1'b0, bus_wdata[31:PER_W]};

  // next-state
  always_comb begin
    auto_d = auto_q; pol_d = pol_q;
    src_d  = src_q;  ien_d = ien_q; pen_d = pen_q; ren_d = ren_q;
    thr_d  = thr_q;  idb_d = idb_q; sdb_d = sdb_q;
    nper_d = nper_q; hper_d = hper_q;
    clr    = '0;
    if (wr) begin
      case (bus_addr)
        A_CTRL: begin
          auto_d = bus_wdata[0];
          src_d  = bus_wdata[4 +: NCH];
          pol_d  = bus_wdata[8];
        end
        A_ENA: begin
          ien_d = bus_wdata[0 +: NCH];
          pen_d = bus_wdata[4 +: NCH];
          ren_d = bus_wdata[8 +: NCH];
        end
        A_PEND: clr    = bus_wdata[NCH-1:0];
        A_IDB:  idb_d  = bus_wdata[DB_W-1:0];
        A_SDB:  sdb_d  = bus_wdata[DB_W-1:0];
        A_NPER: nper_d = bus_wdata[PER_W-1:0];
        A_HPER: hper_d = bus_wdata[PER_W-1:0];
        default: ;
      endcase
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == 8'(A_THR0 + 4*c)) thr_d[c] = bus_wdata[CODE_W-1:0];
      end
    end
    pend_d = (pend_q & ~clr) | int_evt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0; pol_q <= 1'b0;
      src_q  <= '0; ien_q <= '0; pen_q <= '0; ren_q <= '0;
      thr_q  <= '0; pend_q <= '0;
      idb_q  <= DB_W'(DEF_DB);    sdb_q  <= DB_W'(DEF_DB);
      nper_q <= PER_W'(DEF_NORM); hper_q <= PER_W'(DEF_HOT);
    end else begin
      auto_q <= auto_d; pol_q <= pol_d;
      src_q  <= src_d;  ien_q <= ien_d; pen_q <= pen_d; ren_q <= ren_d;
      thr_q  <= thr_d;  pend_q <= pend_d;
      idb_q  <= idb_d;  sdb_q  <= sdb_d;
      nper_q <= nper_d; hper_q <= hper_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]        = auto_q;
        bus_rdata[4 +: NCH] = src_q;
        bus_rdata[8]        = pol_q;
      end
      A_ENA: begin
        bus_rdata[0 +: NCH] = ien_q;
        bus_rdata[4 +: NCH] = pen_q;
        bus_rdata[8 +: NCH] = ren_q;
      end
      A_PEND: bus_rdata[NCH-1:0]   = pend_q;
      A_IDB:  bus_rdata[DB_W-1:0]  = idb_q;
      A_SDB:  bus_rdata[DB_W-1:0]  = sdb_q;
      A_NPER: bus_rdata[PER_W-1:0] = nper_q;
      A_HPER: bus_rdata[PER_W-1:0] = hper_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == 8'(A_DATA0 + 4*c)) bus_rdata[CODE_W-1:0] = chan_data[c];
      if (bus_addr == 8'(A_THR0 + 4*c))  bus_rdata[CODE_W-1:0] = thr_q[c];
    end
  end

  assign auto_en  = auto_q;
  assign src_en   = src_q;
  assign shut_pol = pol_q;
  assign int_en   = ien_q;
  assign pin_en   = pen_q;
  assign rst_en   = ren_q;
  assign thr      = thr_q;
  assign int_db   = idb_q;
  assign shut_db  = sdb_q;
  assign norm_per = nper_q;
  assign hot_per  = hper_q;
  assign pend     = pend_q;
endmodule

// File: rtl/tadc_seq.sv
module tadc_seq
  import tadc_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int PER_W = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_en,
  input  logic [NCH-1:0]   src_en,
  input  logic             hot,
  input  logic [PER_W-1:0] norm_per,
  input  logic [PER_W-1:0] hot_per,
  input  logic             adc_done,
  output logic             adc_start,
  output logic [CH_W-1:0]  adc_chan,
  output logic             smp_vld,
  output logic [CH_W-1:0]  smp_ch
);
  seq_state_e       st_q, st_d;
  logic [CH_W-1:0]  cur_q, cur_d, nxt_ch;
  logic [PER_W-1:0] cnt_q, cnt_d, per;
  logic             nxt_ok;

  assign per = hot ? hot_per : norm_per;

  // round-robin pick: smallest forward offset from the current channel wins
  always_comb begin
    nxt_ch = cur_q;
    nxt_ok = 1'b0;
    for (int k = NCH; k >= 1; k--) begin
      if ((CH_W'((int'(cur_q) + k) % NCH) != '0) &&
          src_en[CH_W'((int'(cur_q) + k) % NCH)]) begin
        nxt_ch = CH_W'((int'(cur_q) + k) % NCH);
        nxt_ok = 1'b1;
      end
    end
  end

  // next-state
  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_IDLE: if (auto_en && nxt_ok) begin
        st_d  = SQ_START;
        cur_d = nxt_ch;
      end
      SQ_START: st_d = SQ_BUSY;
      SQ_BUSY: if (adc_done) begin
        st_d  = SQ_WAIT;
        cnt_d = '0;
      end
      SQ_WAIT: begin
        if (!auto_en || !nxt_ok) begin
          st_d = SQ_IDLE;
        end else if (cnt_q >= per) begin
          st_d  = SQ_START;
          cur_d = nxt_ch;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign adc_start = (st_q == SQ_START);
  assign adc_chan  = cur_q;
  assign smp_vld   = (st_q == SQ_BUSY) && adc_done;
  assign smp_ch    = cur_q;
endmodule

// File: rtl/tadc_chan.sv
module tadc_chan
  import tadc_pkg::*;
#(
  parameter int DB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] thr,
  input  logic [DB_W-1:0]   int_db,
  input  logic [DB_W-1:0]   shut_db,
  output logic [CODE_W-1:0] data,
  output logic              over,
  output logic              int_evt,
  output logic              shut_hit
);
  logic [CODE_W-1:0] data_q, data_d;
  logic              vld_q, vld_d, hit_q, hit_d, code_over;
  logic [DB_W-1:0]   icnt_q, icnt_d, scnt_q, scnt_d, icnt_inc, scnt_inc;

  assign code_over = (code <= thr);
  assign icnt_inc  = (icnt_q == '1) ? icnt_q : icnt_q + 1'b1;
  assign scnt_inc  = (scnt_q == '1) ? scnt_q : scnt_q + 1'b1;
  assign int_evt   = smp && code_over && (icnt_inc >= int_db);

  // next-state
  always_comb begin
    data_d = data_q;
    vld_d  = vld_q;
    icnt_d = icnt_q;
    scnt_d = scnt_q;
    hit_d  = hit_q;
    if (smp) begin
      data_d = code;
      vld_d  = 1'b1;
      icnt_d = code_over ? icnt_inc : '0;
      scnt_d = code_over ? scnt_inc : '0;
      if (code_over && (scnt_inc >= shut_db)) hit_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      icnt_q <= '0;
      scnt_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
      icnt_q <= icnt_d;
      scnt_q <= scnt_d;
      hit_q  <= hit_d;
    end
  end

  assign data     = data_q;
  assign over     = vld_q && (data_q <= thr);
  assign shut_hit = hit_q;
endmodule

// File: rtl/tadc_monitor.sv
module tadc_monitor
  import tadc_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int PER_W    = 16,
  parameter int DB_W     = 8,
  parameter int DEF_NORM = 250,
  parameter int DEF_HOT  = 50,
  parameter int DEF_DB   = 4,
  localparam int CH_W    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  input  logic              adc_done,
  input  logic [CODE_W-1:0] adc_code,
  output logic              irq,
  output logic              shut_pin,
  output logic              shut_rst
);
  logic [1:0]                 rs_q;
  logic                       rst_s_n;
  logic                       auto_en, shut_pol, hot, smp_vld;
  logic [CH_W-1:0]            smp_ch;
  logic [NCH-1:0]             src_en, int_en, pin_en, rst_en, pend;
  logic [NCH-1:0]             chan_over, int_evt, shut_hit;
  logic [NCH-1:0][CODE_W-1:0] thr, chan_data;
  logic [DB_W-1:0]            int_db, shut_db;
  logic [PER_W-1:0]           norm_per, hot_per;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  tadc_regs #(
    .NCH(NCH), .PER_W(PER_W), .DB_W(DB_W),
    .DEF_NORM(DEF_NORM), .DEF_HOT(DEF_HOT), .DEF_DB(DEF_DB)
  ) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_data(chan_data), .int_evt(int_evt),
    .auto_en(auto_en), .src_en(src_en), .shut_pol(shut_pol),
    .int_en(int_en), .pin_en(pin_en), .rst_en(rst_en),
    .thr(thr), .int_db(int_db), .shut_db(shut_db),
    .norm_per(norm_per), .hot_per(hot_per), .pend(pend)
  );

  tadc_seq #(.NCH(NCH), .PER_W(PER_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .tick(tick),
    .auto_en(auto_en), .src_en(src_en), .hot(hot),
    .norm_per(norm_per), .hot_per(hot_per),
    .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
    .smp_vld(smp_vld), .smp_ch(smp_ch)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tadc_chan #(.DB_W(DB_W)) u_ch (
      .clk(clk), .rst_n(rst_s_n),
      .smp(smp_vld && (smp_ch == CH_W'(g))),
      .code(adc_code), .thr(thr[g]),
      .int_db(int_db), .shut_db(shut_db),
      .data(chan_data[g]), .over(chan_over[g]),
      .int_evt(int_evt[g]), .shut_hit(shut_hit[g])
    );
  end

  assign hot      = |(chan_over & src_en);
  assign irq      = |(pend & int_en);
  assign shut_rst = |(shut_hit & rst_en);
  assign shut_pin = shut_pol ? (|(shut_hit & pin_en)) : ~(|(shut_hit & pin_en));
endmodule

// File: rtl/tadc_monitor_chk.sv
module tadc_monitor_chk #(
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_start,
  input logic [CH_W-1:0] adc_chan,
  input logic [NCH-1:0]  src_en,
  input logic [NCH-1:0]  shut_hit
);
  logic [NCH-1:0] src_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_en;
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R3
  chan_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (adc_chan != '0));

  // R3
  src_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> src_prev[adc_chan]);

  // R10
  shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((shut_hit & $past(shut_hit)) == $past(shut_hit)));
endmodule

bind tadc_monitor tadc_monitor_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .adc_start(adc_start), .adc_chan(adc_chan),
  .src_en(src_en), .shut_hit(shut_hit)
);

// File: tb/tadc_monitor_bench.sv
module tadc_monitor_bench;
  logic        clk, rst_n, tick;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        adc_start, adc_done;
  logic [1:0]  adc_chan;
  logic [11:0] adc_code;
  logic        irq, shut_pin, shut_rst;

  int nchk, nfail, cyc;
  int nstart, last_start, prev_start;
  int nsamp [0:2];
  logic [1:0]  slog [0:31];
  int          slog_n;
  logic [11:0] code_of [0:2];
  bit          finished;

  tadc_monitor u_tadc_monitor (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_code(adc_code),
    .irq(irq), .shut_pin(shut_pin), .shut_rst(shut_rst)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // converter model: done three cycles after start
  initial begin
    logic [1:0] m_ch;
    int m_dly;
    bit m_busy;
    adc_done = 1'b0; adc_code = '0; m_busy = 0; m_dly = 0; m_ch = '0;
    nstart = 0; last_start = 0; prev_start = 0; slog_n = 0;
    for (int i = 0; i < 3; i++) nsamp[i] = 0;
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (adc_start) begin
        m_ch = adc_chan; m_dly = 3; m_busy = 1;
        nstart++;
        prev_start = last_start; last_start = cyc;
        if (slog_n < 32) begin slog[slog_n] = adc_chan; slog_n++; end
      end else if (m_busy) begin
        m_dly--;
        if (m_dly == 0) begin
          adc_done = 1'b1;
          adc_code = code_of[m_ch];
          m_busy = 0;
          nsamp[m_ch]++;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_samples(input int ch, input int n);
    int target;
    target = nsamp[ch] + n;
    while (nsamp[ch] < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(output int d);
    int n0;
    n0 = nstart;
    while (nstart == n0) @(negedge clk);
    n0 = nstart;
    while (nstart == n0) @(negedge clk);
    d = last_start - prev_start;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_and_reset();
    bwrite(8'h04, 32'h0);
    repeat (20) @(negedge clk);
    do_reset();
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    bread(8'h20, d); check("R1 data0", d, 0);
    bread(8'h24, d); check("R1 data1", d, 0);
    bread(8'h28, d); check("R1 data2", d, 0);
    bread(8'h0C, d); check("R1 pend", d, 0);
    bread(8'h68, d); check("R1 norm period", d, 250);
    bread(8'h6C, d); check("R1 hot period", d, 50);
    bread(8'h60, d); check("R1 int debounce", d, 4);
    bread(8'h64, d); check("R1 shut debounce", d, 4);
    check("R1 irq", irq, 0);
    check("R1 shut_pin idle high", shut_pin, 1);
    check("R1 shut_rst", shut_rst, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bwrite(8'h08, 32'h0000_0762);
    bread(8'h08, d); check("R2 enable fields", d, 32'h762);
    bwrite(8'h04, 32'h0000_0170);
    bread(8'h04, d); check("R2 control fields", d, 32'h170);
    repeat (10) @(negedge clk);
    check("R2 no start without auto enable", nstart, 0);
    bwrite(8'h0C, 32'hFFFF_FFFF);
    bread(8'h0C, d); check("R2 pend write-one only clears", d, 0);
    bwrite(8'h08, 32'h0);
    bwrite(8'h04, 32'h0);
  endtask

  task automatic t_round_robin();
    logic [31:0] d;
    bit ok;
    bwrite(8'h68, 20);
    bwrite(8'h6C, 5);
    code_of[0] = 12'd3000; code_of[1] = 12'd3700; code_of[2] = 12'd3650;
    slog_n = 0;
    bwrite(8'h04, 32'h61);
    while (slog_n < 6) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (slog[i] == 2'd0 || slog[i] == 2'd3) ok = 0;
      if (i > 0 && slog[i] == slog[i-1]) ok = 0;
    end
    check("R3 alternating channels 1 and 2", ok, 1);
    wait_samples(2, 1);
    bread(8'h24, d); check("R4 data ch1", d, 3700);
    bread(8'h28, d); check("R4 data ch2", d, 3650);
    bread(8'h20, d); check("R3 channel 0 never converted", d, 0);
    bwrite(8'h04, 32'h41);
    wait_samples(2, 1);
    slog_n = 0;
    while (slog_n < 3) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 3; i++) if (slog[i] != 2'd2) ok = 0;
    check("R3 only enabled channel converted", ok, 1);
  endtask

  task automatic t_periods();
    int dc, dh, n0;
    bwrite(8'h04, 32'h21);
    wait_samples(1, 1);
    measure(dc);
    check("R5 normal interval", dc, 25);
    bwrite(8'h44, 3700);          // R7 equal code counts as over
    wait_samples(1, 1);
    measure(dh);
    check("R6 hot interval", dh, 10);
    check("R7 equality selects hot period", dc - dh, 15);
    tick = 1'b0;
    n0 = nstart;
    repeat (60) @(negedge clk);
    check("R5 no start while tick low", (nstart - n0) <= 1, 1);
    tick = 1'b1;
    repeat (40) @(negedge clk);
    check("R5 resumes with tick", (nstart - n0) >= 2, 1);
  endtask

  task automatic t_int_debounce();
    logic [31:0] d;
    code_of[1] = 12'd3800;
    wait_samples(1, 2);
    bwrite(8'h0C, 32'h7);
    bwrite(8'h08, 32'h2);
    check("R8 irq low when cool", irq, 0);
    code_of[1] = 12'd3700;
    wait_samples(1, 3);
    check("R8 three over samples no irq", irq, 0);
    code_of[1] = 12'd3701;
    wait_samples(1, 1);
    code_of[1] = 12'd3700;
    wait_samples(1, 3);
    check("R8 count restarted by cool sample", irq, 0);
    wait_samples(1, 1);
    check("R8 irq after fourth consecutive", irq, 1);
    bread(8'h0C, d); check("R8 pend bit ch1", d, 32'h2);
  endtask

  task automatic t_w1c_mask();
    logic [31:0] d;
    code_of[1] = 12'd3800;
    wait_samples(1, 1);
    bwrite(8'h0C, 32'h0);
    bread(8'h0C, d); check("R9 write zero keeps pend", d, 32'h2);
    check("R9 irq stays", irq, 1);
    bwrite(8'h0C, 32'h2);
    bread(8'h0C, d); check("R9 write one clears", d, 0);
    check("R9 irq drops", irq, 0);
    bwrite(8'h08, 32'h0);
    code_of[1] = 12'd3700;
    wait_samples(1, 4);
    bread(8'h0C, d); check("R9 pend sets while masked", d, 32'h2);
    check("R9 irq masked", irq, 0);
    bwrite(8'h08, 32'h2);
    check("R9 irq on unmask", irq, 1);
  endtask

  task automatic t_shut_pin();
    stop_and_reset();
    check("R1 shut_pin inactive after reset", shut_pin, 1);
    bwrite(8'h68, 20);
    bwrite(8'h6C, 5);
    bwrite(8'h64, 2);
    bwrite(8'h48, 3650);
    bwrite(8'h08, 32'h40);        // ch2 to pin
    code_of[2] = 12'd3650;
    bwrite(8'h04, 32'h41);
    wait_samples(2, 1);
    check("R10 one sample no shutdown", shut_pin, 1);
    wait_samples(2, 1);
    check("R11 pin active low", shut_pin, 0);
    check("R11 reset request not routed", shut_rst, 0);
    code_of[2] = 12'd3800;
    wait_samples(2, 2);
    check("R10 latched after cooling", shut_pin, 0);
    bwrite(8'h04, 32'h141);
    check("R11 pin active high", shut_pin, 1);
  endtask

  task automatic t_shut_rst();
    stop_and_reset();
    bwrite(8'h68, 20);
    bwrite(8'h6C, 5);
    bwrite(8'h64, 3);
    bwrite(8'h44, 3700);
    bwrite(8'h08, 32'h200);       // ch1 to reset request
    code_of[1] = 12'd3690;
    bwrite(8'h04, 32'h21);
    wait_samples(1, 2);
    check("R10 two samples below count", shut_rst, 0);
    wait_samples(1, 1);
    check("R11 reset request", shut_rst, 1);
    check("R11 pin untouched", shut_pin, 1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int n0;
    code_of[1] = 12'd3333;
    n0 = nstart;
    while (nstart == n0) @(negedge clk);
    bwrite(8'h04, 32'h20);
    n0 = nstart;
    repeat (80) @(negedge clk);
    check("R12 no start after disable", nstart, n0);
    bread(8'h24, d); check("R12 in-flight result stored", d, 3333);
  endtask

  initial begin
    nchk = 0; nfail = 0; finished = 0;
    rst_n = 1'b0; tick = 1'b1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 3; i++) code_of[i] = 12'd3800;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_regmap();
    t_round_robin();
    t_periods();
    t_int_debounce();
    t_w1c_mask();
    t_shut_pin();
    t_shut_rst();
    t_disable();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule